// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block holds the line reservations that pair a locked read with the locked write that follows it on the data side of a cache front end. When a locked read from the data side completes, the block records a reservation for that cache line and tags it with the ID of the requester. Later, before a locked write leaves for the cache controller, the write's line and requester ID are presented as a check. The check passes only if that line is still reserved by that requester. A pass consumes the reservation and releases the write toward the controller as a store-class command. A fail sends nothing.

Reservations are lost in three ways. A plain store from any requester to the line clears it. An optional coherence invalidate for the line clears it. A newer locked-read completion takes the slot when the table is full. The table has a parameter number of slots. When every slot is busy, the slot that was filled longest ago is reused. The result of each check is registered and appears one cycle after the check is presented.

Top module: `resv_monitor`

## Requirements
- R1: After reset no line is reserved, and `res_valid` and `iss_valid` are 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `chk_valid` = 1, and 0 otherwise.
- R3: A check passes (`res_pass` = 1) when its line is reserved with the same requester ID. On a pass, `iss_valid` = 1 and `iss_line` equals the checked line, in the same cycle as the result.
- R4: A check fails when its line holds no reservation or when the reservation belongs to another ID. A failed check raises no `iss_valid` and leaves the reservation untouched.
- R5: A passing check consumes the reservation, so a second check of the same line and ID then fails.
- R6: A reservation is set only by a completion with `cmp_valid`, `cmp_locked` and `cmp_dside` all 1. Instruction-side (`cmp_dside` = 0) and unlocked completions set nothing.
- R7: A line is held by at most one slot. A locked completion to a line that is already reserved replaces the owner ID with the new one.
- R8: A plain store (`st_valid`) to a reserved line clears that reservation, whatever its owner.
- R9: With `INV_EN` = 1, an invalidate (`inv_valid`) to a reserved line clears that reservation.
- R10: When all `NUM_SLOTS` slots are busy, a locked completion to a new line evicts the slot whose reservation was set or refreshed least recently.
- R11: Within one cycle, a check sees the reservations as they stood before that cycle's events. A locked completion in the same cycle as a store or invalidate to its line leaves the line reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | A read completion is reported this cycle |
| cmp_locked | input | 1 | The completing read was a locked read |
| cmp_dside | input | 1 | The completion came from the data side (0 means the instruction side) |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_id | input | ID_W | Requester ID of the completion |
| st_valid | input | 1 | A plain store to `st_line` is seen |
| st_line | input | LINE_W | Line address of the plain store |
| inv_valid | input | 1 | A coherence invalidate for `inv_line` |
| inv_line | input | LINE_W | Line address being invalidated |
| chk_valid | input | 1 | A locked write asks for its reservation check |
| chk_line | input | LINE_W | Line address of the locked write |
| chk_id | input | ID_W | Requester ID of the locked write |
| res_valid | output | 1 | Check result is valid (one cycle after `chk_valid`) |
| res_pass | output | 1 | Check passed |
| iss_valid | output | 1 | Locked write released to the controller as a store-class command |
| iss_line | output | LINE_W | Line address of the released write |

## Verification
The hardest state to reach from the ports is a full table in which one cycle carries a store, an invalidate, a check and a locked completion all at once. In that state the victim choice, the clears and the age order all interact. The random stimulus draws lines from only eight values and IDs from four, against four slots. This keeps the table full and makes line collisions between the simultaneous events common. Directed sequences first pin down eviction order, owner replacement, and the same-cycle check and completion cases. The expected results come from a bench model that orders slots by a fill stamp, not by the rank counters the design keeps.

// File: rtl/resv_pkg.sv
package resv_pkg;

   // Index width that stays legal for a single-entry table.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/resv_slot.sv
// One reservation entry: holds the line, the owner and the age rank,
// and compares its line against every query line.
module resv_slot #(
   parameter int unsigned LINE_W = 26,
   parameter int unsigned ID_W   = 4,
   parameter int unsigned AGE_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              kill,
   input  logic [AGE_W-1:0]  age_nxt,
   input  logic [LINE_W-1:0] new_line,
   input  logic [ID_W-1:0]   new_id,
   input  logic [LINE_W-1:0] q_cmp_line,
   input  logic [LINE_W-1:0] q_st_line,
   input  logic [LINE_W-1:0] q_inv_line,
   input  logic [LINE_W-1:0] q_chk_line,
   input  logic [ID_W-1:0]   q_chk_id,
   output logic              vld,
   output logic [AGE_W-1:0]  age,
   output logic              m_cmp,
   output logic              m_st,
   output logic              m_inv,
   output logic              m_chk_line,
   output logic              m_chk
);

   logic [LINE_W-1:0] line_q;
   logic [ID_W-1:0]   id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         line_q <= '0;
         id_q   <= '0;
         age    <= '0;
      end else begin
         age <= age_nxt;
         if (load) begin
            vld    <= 1'b1;
            line_q <= new_line;
            id_q   <= new_id;
         end else if (kill) begin
            vld <= 1'b0;
         end
      end
   end

   always_comb begin
      m_cmp      = vld && (line_q == q_cmp_line);
      m_st       = vld && (line_q == q_st_line);
      m_inv      = vld && (line_q == q_inv_line);
      m_chk_line = vld && (line_q == q_chk_line);
      m_chk      = m_chk_line && (id_q == q_chk_id);
   end

endmodule

// File: rtl/resv_victim.sv
// Chooses the slot a locked completion writes: the slot already holding
// the line, else the lowest free slot, else the oldest busy slot.
module resv_victim #(
   parameter int unsigned N     = 4,
   parameter int unsigned IW    = 2,
   parameter int unsigned AGE_W = 2
) (
   input  logic [N-1:0]            vld,
   input  logic [N-1:0]            same,
   input  logic [N-1:0][AGE_W-1:0] age,
   output logic [IW-1:0]           vic
);

   if (N == 1) begin : g_single
      assign vic = '0;
   end else begin : g_multi
      logic             hit_found;
      logic             free_found;
      logic [IW-1:0]    hit_idx;
      logic [IW-1:0]    free_idx;
      logic [IW-1:0]    old_idx;
      logic [AGE_W-1:0] old_age;

      always_comb begin
         hit_found  = 1'b0;
         free_found = 1'b0;
         hit_idx    = '0;
         free_idx   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (same[i]) begin
               hit_found = 1'b1;
               hit_idx   = IW'(i);
            end
            if (!vld[i]) begin
               free_found = 1'b1;
               free_idx   = IW'(i);
            end
         end
         old_idx = '0;
         old_age = age[0];
         for (int i = 1; i < N; i++) begin
            if (age[i] > old_age) begin
               old_age = age[i];
               old_idx = IW'(i);
            end
         end
         if (hit_found)       vic = hit_idx;
         else if (free_found) vic = free_idx;
         else                 vic = old_idx;
      end
   end

endmodule

// File: rtl/resv_age.sv
// Age rank per slot = number of busy slots filled after it.
// Removed slots younger than a survivor lower its rank; a new fill raises it.
module resv_age #(
   parameter int unsigned N     = 4,
   parameter int unsigned AGE_W = 2
) (
   input  logic [N-1:0]            vld,
   input  logic [N-1:0]            rm,
   input  logic [N-1:0]            load,
   input  logic                    fill,
   input  logic [N-1:0][AGE_W-1:0] age,
   output logic [N-1:0][AGE_W-1:0] age_nxt
);

   for (genvar i = 0; i < N; i++) begin : g_row
      logic [AGE_W-1:0] gone;
      always_comb begin
         gone = '0;
         for (int j = 0; j < N; j++) begin
            if (rm[j] && (age[j] < age[i])) gone = gone + AGE_W'(1);
         end
         if (load[i])
            age_nxt[i] = '0;
         else if (vld[i] && !rm[i])
            age_nxt[i] = age[i] - gone + AGE_W'(fill);
         else
            age_nxt[i] = age[i];
      end
   end

endmodule

// File: rtl/resv_result.sv
// Registered check outcome and the release of the store-class write.
module resv_result #(
   parameter int unsigned LINE_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_valid,
   input  logic              owner_hit,
   input  logic [LINE_W-1:0] chk_line,
   output logic              res_valid,
   output logic              res_pass,
   output logic              iss_valid,
   output logic [LINE_W-1:0] iss_line
);

   logic grant;
   assign grant = chk_valid && owner_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_pass  <= 1'b0;
         iss_valid <= 1'b0;
         iss_line  <= '0;
      end else begin
         res_valid <= chk_valid;
         res_pass  <= grant;
         iss_valid <= grant;
         if (grant) iss_line <= chk_line;
      end
   end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
   parameter int unsigned LINE_W    = 26,
   parameter int unsigned ID_W      = 4,
   parameter int unsigned NUM_SLOTS = 4,
   parameter bit          INV_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_valid,
   input  logic              cmp_locked,
   input  logic              cmp_dside,
   input  logic [LINE_W-1:0] cmp_line,
   input  logic [ID_W-1:0]   cmp_id,
   input  logic              st_valid,
   input  logic [LINE_W-1:0] st_line,
   input  logic              inv_valid,
   input  logic [LINE_W-1:0] inv_line,
   input  logic              chk_valid,
   input  logic [LINE_W-1:0] chk_line,
   input  logic [ID_W-1:0]   chk_id,
   output logic              res_valid,
   output logic              res_pass,
   output logic              iss_valid,
   output logic [LINE_W-1:0] iss_line
);

   localparam int unsigned IW    = resv_pkg::idx_w(NUM_SLOTS);
   localparam int unsigned AGE_W = IW;

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("resv_monitor: NUM_SLOTS must be at least 1");
   end
   if (LINE_W < 1) begin : g_bad_line
      $error("resv_monitor: LINE_W must be at least 1");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("resv_monitor: ID_W must be at least 1");
   end

   logic [NUM_SLOTS-1:0]            slot_vld;
   logic [NUM_SLOTS-1:0][AGE_W-1:0] slot_age;
   logic [NUM_SLOTS-1:0][AGE_W-1:0] slot_age_nxt;
   logic [NUM_SLOTS-1:0]            cmp_hit;
   logic [NUM_SLOTS-1:0]            st_hit;
   logic [NUM_SLOTS-1:0]            inv_hit_raw;
   logic [NUM_SLOTS-1:0]            inv_hit;
   logic [NUM_SLOTS-1:0]            chk_line_hit;
   logic [NUM_SLOTS-1:0]            chk_hit;
   logic [NUM_SLOTS-1:0]            kill;
   logic [NUM_SLOTS-1:0]            load;
   logic [NUM_SLOTS-1:0]            removed;
   logic [IW-1:0]                   victim;
   logic                            fill;

   assign fill = cmp_valid && cmp_locked && cmp_dside;

   if (INV_EN) begin : g_inv_on
      assign inv_hit = inv_valid ? inv_hit_raw : '0;
   end else begin : g_inv_off
      assign inv_hit = '0;
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign kill[i] = (st_valid && st_hit[i]) || inv_hit[i] ||
                       (chk_valid && chk_hit[i]);
      assign load[i] = fill && (victim == IW'(i));

      resv_slot #(
         .LINE_W (LINE_W),
         .ID_W   (ID_W),
         .AGE_W  (AGE_W)
      ) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load[i]),
         .kill       (kill[i]),
         .age_nxt    (slot_age_nxt[i]),
         .new_line   (cmp_line),
         .new_id     (cmp_id),
         .q_cmp_line (cmp_line),
         .q_st_line  (st_line),
         .q_inv_line (inv_line),
         .q_chk_line (chk_line),
         .q_chk_id   (chk_id),
         .vld        (slot_vld[i]),
         .age        (slot_age[i]),
         .m_cmp      (cmp_hit[i]),
         .m_st       (st_hit[i]),
         .m_inv      (inv_hit_raw[i]),
         .m_chk_line (chk_line_hit[i]),
         .m_chk      (chk_hit[i])
      );
   end

   assign removed = slot_vld & (kill | load);

   resv_victim #(
      .N     (NUM_SLOTS),
      .IW    (IW),
      .AGE_W (AGE_W)
   ) u_victim (
      .vld  (slot_vld),
      .same (cmp_hit),
      .age  (slot_age),
      .vic  (victim)
   );

   resv_age #(
      .N     (NUM_SLOTS),
      .AGE_W (AGE_W)
   ) u_age (
      .vld     (slot_vld),
      .rm      (removed),
      .load    (load),
      .fill    (fill),
      .age     (slot_age),
      .age_nxt (slot_age_nxt)
   );

   resv_result #(
      .LINE_W (LINE_W)
   ) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .chk_valid (chk_valid),
      .owner_hit (|chk_hit),
      .chk_line  (chk_line),
      .res_valid (res_valid),
      .res_pass  (res_pass),
      .iss_valid (iss_valid),
      .iss_line  (iss_line)
   );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
   parameter int unsigned LINE_W    = 26,
   parameter int unsigned NUM_SLOTS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 chk_valid,
   input logic [LINE_W-1:0]    chk_line,
   input logic                 res_valid,
   input logic                 res_pass,
   input logic                 iss_valid,
   input logic [LINE_W-1:0]    iss_line,
   input logic [NUM_SLOTS-1:0] hit_vec,
   input logic [NUM_SLOTS-1:0] line_vec
);

   p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> res_valid);

   p_no_stray_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !res_valid);

   p_issue_needs_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (res_valid && res_pass));

   p_issue_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (iss_line == $past(chk_line)));

   p_no_owner_fails_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && (hit_vec == '0)) |=> !res_pass);

   p_single_holder_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(line_vec));

endmodule

bind resv_monitor resv_monitor_chk #(
   .LINE_W    (LINE_W),
   .NUM_SLOTS (NUM_SLOTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chk_valid (chk_valid),
   .chk_line  (chk_line),
   .res_valid (res_valid),
   .res_pass  (res_pass),
   .iss_valid (iss_valid),
   .iss_line  (iss_line),
   .hit_vec   (chk_hit),
   .line_vec  (chk_line_hit)
);

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;

   localparam int LW = 26;
   localparam int DW = 4;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_valid = 0, cmp_locked = 0, cmp_dside = 0;
   logic [LW-1:0] cmp_line = '0;
   logic [DW-1:0] cmp_id = '0;
   logic          st_valid = 0;
   logic [LW-1:0] st_line = '0;
   logic          inv_valid = 0;
   logic [LW-1:0] inv_line = '0;
   logic          chk_valid = 0;
   logic [LW-1:0] chk_line = '0;
   logic [DW-1:0] chk_id = '0;
   logic          res_valid, res_pass, iss_valid;
   logic [LW-1:0] iss_line;

   int vectors = 0;
   int misses  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   resv_monitor #(.LINE_W(LW), .ID_W(DW), .NUM_SLOTS(NS), .INV_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .cmp_valid(cmp_valid), .cmp_locked(cmp_locked), .cmp_dside(cmp_dside),
      .cmp_line(cmp_line), .cmp_id(cmp_id),
      .st_valid(st_valid), .st_line(st_line),
      .inv_valid(inv_valid), .inv_line(inv_line),
      .chk_valid(chk_valid), .chk_line(chk_line), .chk_id(chk_id),
      .res_valid(res_valid), .res_pass(res_pass),
      .iss_valid(iss_valid), .iss_line(iss_line)
   );

   // Reference table: a slot's fill stamp orders its age.
   bit m_v [NS];
   int m_line [NS];
   int m_id [NS];
   int m_stamp [NS];
   int stamp_ctr = 0;

   function automatic bit model_has(input int line, input int id);
      for (int i = 0; i < NS; i++)
         if (m_v[i] && m_line[i] == line && m_id[i] == id) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int model_victim(input int line);
      int best;
      for (int i = 0; i < NS; i++)
         if (m_v[i] && m_line[i] == line) return i;
      for (int i = 0; i < NS; i++)
         if (!m_v[i]) return i;
      best = 0;
      for (int i = 1; i < NS; i++)
         if (m_stamp[i] < m_stamp[best]) best = i;
      return best;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < NS; i++) m_v[i] = 1'b0;
   endtask

   task automatic model_step(input bit fill, input int cline, input int cid,
                             input bit sv, input int sline, input bit iv,
                             input int iline, input bit kv, input int kline,
                             input int kid);
      int vic;
      vic = model_victim(cline);
      for (int i = 0; i < NS; i++) begin
         if (m_v[i] && sv && m_line[i] == sline) m_v[i] = 1'b0;
         else if (m_v[i] && iv && m_line[i] == iline) m_v[i] = 1'b0;
         else if (m_v[i] && kv && m_line[i] == kline && m_id[i] == kid) m_v[i] = 1'b0;
      end
      if (fill) begin
         m_v[vic]     = 1'b1;
         m_line[vic]  = cline;
         m_id[vic]    = cid;
         m_stamp[vic] = stamp_ctr;
         stamp_ctr++;
      end
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // One clock: drive at the falling edge, sample at the next falling edge.
   task automatic tick(input bit cv, input bit cl, input bit cd, input int cline,
                       input int cid, input bit sv, input int sline, input bit iv,
                       input int iline, input bit kv, input int kline, input int kid,
                       input string tag);
      bit exp_pass;
      cmp_valid = cv; cmp_locked = cl; cmp_dside = cd;
      cmp_line = LW'(cline); cmp_id = DW'(cid);
      st_valid = sv; st_line = LW'(sline);
      inv_valid = iv; inv_line = LW'(iline);
      chk_valid = kv; chk_line = LW'(kline); chk_id = DW'(kid);
      exp_pass = kv && model_has(kline, kid);
      model_step(cv && cl && cd, cline, cid, sv, sline, iv, iline, kv, kline, kid);
      @(posedge clk);
      @(negedge clk);
      check(res_valid == kv, "R2", "res_valid", int'(res_valid), int'(kv));
      if (kv) begin
         check(res_pass == exp_pass, tag, "res_pass", int'(res_pass), int'(exp_pass));
         check(iss_valid == exp_pass, tag, "iss_valid", int'(iss_valid), int'(exp_pass));
         if (exp_pass)
            check(int'(iss_line) == kline, "R3", "iss_line", int'(iss_line), kline);
      end else begin
         check(iss_valid == 1'b0, "R4", "iss_valid idle", int'(iss_valid), 0);
      end
      cmp_valid = 0; st_valid = 0; inv_valid = 0; chk_valid = 0;
   endtask

   task automatic set_rsv(input int line, input int id);
      tick(1, 1, 1, line, id, 0, 0, 0, 0, 0, 0, 0, "R6");
   endtask

   task automatic probe(input int line, input int id, input string tag);
      tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, line, id, tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      do_reset();
      // R1: clean state after reset
      check(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
      check(iss_valid == 1'b0, "R1", "iss_valid", int'(iss_valid), 0);
      probe(5, 1, "R1");

      // R6: instruction-side and unlocked completions set nothing
      tick(1, 1, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
      probe(3, 1, "R6");
      tick(1, 0, 1, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
      probe(3, 1, "R6");

      // R3 pass, R5 consumed
      set_rsv(3, 1);
      probe(3, 1, "R3");
      probe(3, 1, "R5");

      // R4 wrong owner fails and keeps the reservation
      set_rsv(4, 2);
      probe(4, 1, "R4");
      probe(4, 2, "R4");

      // R7 owner replaced
      set_rsv(6, 1);
      set_rsv(6, 2);
      probe(6, 1, "R7");
      probe(6, 2, "R7");

      // R8 plain store clears
      set_rsv(7, 0);
      tick(0, 0, 0, 0, 0, 1, 7, 0, 0, 0, 0, 0, "R8");
      probe(7, 0, "R8");

      // R9 invalidate clears
      set_rsv(2, 3);
      tick(0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, "R9");
      probe(2, 3, "R9");

      // R10 oldest evicted, refresh counts as new
      do_reset();
      set_rsv(10, 1); set_rsv(11, 1); set_rsv(12, 1); set_rsv(13, 1);
      set_rsv(10, 1);
      set_rsv(14, 1);
      probe(11, 1, "R10");
      probe(10, 1, "R10");
      probe(12, 1, "R10");
      probe(13, 1, "R10");
      probe(14, 1, "R10");

      // R11 same-cycle orderings
      tick(1, 1, 1, 20, 1, 0, 0, 0, 0, 1, 20, 1, "R11");
      probe(20, 1, "R11");
      tick(1, 1, 1, 21, 2, 1, 21, 1, 21, 0, 0, 0, "R11");
      probe(21, 2, "R11");

      // Random mix over a narrow line range
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         tick($urandom_range(0, 9) < 4, $urandom_range(0, 9) < 7,
              $urandom_range(0, 9) < 8, $urandom_range(0, 7), $urandom_range(0, 3),
              $urandom_range(0, 19) < 3, $urandom_range(0, 7),
              $urandom_range(0, 9) < 1, $urandom_range(0, 7),
              $urandom_range(0, 9) < 4, $urandom_range(0, 7), $urandom_range(0, 3),
              "R11");
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule